// File: doc/BRIEF.md
# Serial Link Transceiver Reset Sequencer

This block decides when the transmit and receive halves of a multi-gigabit serial link may leave reset, once the global active-low power-on reset goes away. First it drops the SERDES reset. The transmit side leaves reset only after its PLL lock indicator has been held high for a fixed run of clock cycles.

The receive side moves through a short detect sequence. From quiet it goes to active once the receive PLL reports lock. From active it goes to polling when the PHY reports a completed receiver detection. In polling the receive digital reset stays asserted until the signal-detect input has been held high for a 3 ms window. The length of that window is derived from the clock frequency, and a test override can shorten it.

A combined reset-status output tells the application layer when both halves are out of reset. If a lock input or the signal-detect input is lost, the matching reset is asserted again. Asserting the power-on reset again restarts the whole sequence.

Top module: `link_rst_seq`

## Requirements
- R1: While `por_n` is low, asynchronously and without waiting for a clock: `serdes_rst`, `tx_dig_rst`, `rx_dig_rst` and `rst_status` are 1 and `det_state` is 0 (quiet). The `det_state` encoding is 0 quiet, 1 active, 2 polling.
- R2: At the first rising clock edge after `por_n` rises, `serdes_rst` falls. Nothing else in the sequence advances on that edge.
- R3: `tx_dig_rst` falls only after `tx_pll_lock` has been sampled high on `TX_LOCK_CYCLES` (default 127) consecutive edges while `serdes_rst` is low. With the lock held high from reset release, it falls on edge 128.
- R4: `det_state` leaves quiet (0) for active (1) on the first edge at which `rx_pll_lock` is high while `serdes_rst` is low. While `rx_pll_lock` stays low, the state stays quiet.
- R5: In active, a synchronized cycle with `phy_status` = 1 and `rx_status` = 3 moves `det_state` to polling (2). A status pulse with any other code, or code 3 with `phy_status` low, leaves the state unchanged.
- R6: `rx_dig_rst` is 1 outside polling. In polling it falls only after the synchronized `sig_det` has been sampled high on the window count of consecutive edges. The window count is `CLK_HZ`·3/1000 cycles unless `SIG_OVERRIDE` is nonzero, in which case `SIG_OVERRIDE` is used.
- R7: `rst_status` is 0 exactly when both `tx_dig_rst` and `rx_dig_rst` are 0.
- R8: A low on `tx_pll_lock` clears the transmit window count, and a low synchronized `sig_det` clears the receive window count. Either low reasserts its digital reset if that reset was already released, and the full window must then elapse again.
- R9: `phy_status`, `rx_status` and `sig_det` each pass through two flops before use. The lock inputs are used directly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous assert |
| tx_pll_lock | input | 1 | Transmit PLL lock indicator |
| rx_pll_lock | input | 1 | Receive PLL lock indicator |
| phy_status | input | 1 | PHY status pulse, asynchronous |
| rx_status | input | 3 | PHY receive status code, asynchronous |
| sig_det | input | 1 | Receive signal detect, asynchronous |
| serdes_rst | output | 1 | SERDES reset, active high |
| tx_dig_rst | output | 1 | Transmit digital reset, active high |
| rx_dig_rst | output | 1 | Receive digital reset, active high |
| rst_status | output | 1 | High while either datapath is held in reset |
| det_state | output | 2 | Detect state: 0 quiet, 1 active, 2 polling |

## Verification
The hardest condition to reach from the ports is a release of the receive reset that is exactly on time. That release needs the detect state in polling, and polling is reached only after a status pulse carrying code 3 has crossed the two-flop synchronizer. The signal-detect window must then run to completion with no gap. The bench first sweeps all seven other status codes, plus code 3 with the pulse low, and confirms the state holds in active. It then sends a single one-cycle code-3 pulse and counts edges from the pulse to the state change and on to the window boundary. It also repeats the transmit window with a lock drop placed at several offsets, so that each restart is measured against a fresh 127-cycle count.

// File: rtl/link_rst_pkg.sv
package link_rst_pkg;

  typedef enum logic [1:0] {
    DET_QUIET  = 2'd0,
    DET_ACTIVE = 2'd1,
    DET_POLL   = 2'd2
  } det_state_t;

  localparam logic [2:0] RX_CODE_DETECTED = 3'd3;

  // Window length in cycles for a 3 ms hold at clock rate hz.
  function automatic int unsigned ms3_cycles(longint unsigned hz, int unsigned ovr);
    longint unsigned c;
    if (ovr != 0) return ovr;
    c = (hz * 3) / 1000;
    if (c == 0) c = 1;
    return int'(c);
  endfunction

  function automatic int unsigned cnt_width(int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/lrs_sync2.sv
module lrs_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/lrs_hold_timer.sv
module lrs_hold_timer #(
  parameter int unsigned LIMIT = 127,
  parameter int unsigned W     = 7
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic level,
  output logic done
);
  localparam logic [W-1:0] LIM = W'(LIMIT);
  logic [W-1:0] run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               run <= '0;
    else if (!en || !level)   run <= '0;
    else if (run != LIM)      run <= run + 1'b1;
  end

  assign done = (run == LIM);
endmodule

// File: rtl/lrs_det_fsm.sv
module lrs_det_fsm
  import link_rst_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       pll_lock,
  input  logic       hit,
  output det_state_t state
);
  det_state_t nxt;

  always_comb begin
    nxt = state;
    if (en) begin
      unique case (state)
        DET_QUIET:  if (pll_lock) nxt = DET_ACTIVE;
        DET_ACTIVE: if (hit)      nxt = DET_POLL;
        default:                  nxt = DET_POLL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= DET_QUIET;
    else        state <= nxt;
  end
endmodule

// File: rtl/link_rst_seq.sv
module link_rst_seq
  import link_rst_pkg::*;
#(
  parameter int unsigned CLK_HZ         = 125_000_000,
  parameter int unsigned SIG_OVERRIDE   = 0,
  parameter int unsigned TX_LOCK_CYCLES = 127
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       tx_pll_lock,
  input  logic       rx_pll_lock,
  input  logic       phy_status,
  input  logic [2:0] rx_status,
  input  logic       sig_det,
  output logic       serdes_rst,
  output logic       tx_dig_rst,
  output logic       rx_dig_rst,
  output logic       rst_status,
  output logic [1:0] det_state
);
  localparam int unsigned SIG_CYCLES = ms3_cycles(CLK_HZ, SIG_OVERRIDE);
  localparam int unsigned SIG_W      = cnt_width(SIG_CYCLES);
  localparam int unsigned TX_W       = cnt_width(TX_LOCK_CYCLES);

  logic       seq_en;
  logic       det_hit;
  logic       tx_ok;
  logic       rx_ok;
  logic       in_poll;
  logic [4:0] sync_q;
  logic       s_phy;
  logic       s_sig;
  logic [2:0] s_stat;
  det_state_t st;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) serdes_rst <= 1'b1;
    else        serdes_rst <= 1'b0;
  end

  assign seq_en = ~serdes_rst;

  lrs_sync2 #(.W(5)) u_sync (
    .clk   (clk),
    .rst_n (por_n),
    .d     ({sig_det, rx_status, phy_status}),
    .q     (sync_q)
  );

  assign s_phy  = sync_q[0];
  assign s_stat = sync_q[3:1];
  assign s_sig  = sync_q[4];

  assign det_hit = s_phy && (s_stat == RX_CODE_DETECTED);

  lrs_hold_timer #(.LIMIT(TX_LOCK_CYCLES), .W(TX_W)) u_tx_tmr (
    .clk   (clk),
    .rst_n (por_n),
    .en    (seq_en),
    .level (tx_pll_lock),
    .done  (tx_ok)
  );

  lrs_det_fsm u_det (
    .clk      (clk),
    .rst_n    (por_n),
    .en       (seq_en),
    .pll_lock (rx_pll_lock),
    .hit      (det_hit),
    .state    (st)
  );

  assign in_poll = (st == DET_POLL);

  lrs_hold_timer #(.LIMIT(SIG_CYCLES), .W(SIG_W)) u_rx_tmr (
    .clk   (clk),
    .rst_n (por_n),
    .en    (in_poll),
    .level (s_sig),
    .done  (rx_ok)
  );

  assign tx_dig_rst = ~tx_ok;
  assign rx_dig_rst = ~rx_ok;
  assign rst_status = tx_dig_rst | rx_dig_rst;
  assign det_state  = st;
endmodule

// File: rtl/link_rst_seq_chk.sv
module link_rst_seq_chk #(
  parameter int unsigned TX_LOCK_CYCLES = 127
) (
  input logic       clk,
  input logic       por_n,
  input logic       tx_pll_lock,
  input logic       rx_pll_lock,
  input logic       serdes_rst,
  input logic       tx_dig_rst,
  input logic       rx_dig_rst,
  input logic       rst_status,
  input logic [1:0] det_state,
  input logic       det_hit
);
  logic [15:0] lock_run;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)                         lock_run <= '0;
    else if (serdes_rst || !tx_pll_lock) lock_run <= '0;
    else if (lock_run != 16'hFFFF)       lock_run <= lock_run + 1'b1;
  end

  assert_serdes_first_R2: assert property (@(posedge clk) disable iff (!por_n)
    serdes_rst |-> (tx_dig_rst && rx_dig_rst && det_state == 2'd0));

  assert_tx_window_R3: assert property (@(posedge clk) disable iff (!por_n)
    !tx_dig_rst |-> (lock_run >= 16'(TX_LOCK_CYCLES)));

  assert_quiet_exit_R4: assert property (@(posedge clk) disable iff (!por_n)
    (det_state == 2'd0) ##1 (det_state == 2'd1) |-> $past(rx_pll_lock));

  assert_poll_entry_R5: assert property (@(posedge clk) disable iff (!por_n)
    (det_state == 2'd1) ##1 (det_state == 2'd2) |-> $past(det_hit));

  assert_rx_hold_R6: assert property (@(posedge clk) disable iff (!por_n)
    (det_state != 2'd2) |-> rx_dig_rst);

  assert_status_R7: assert property (@(posedge clk) disable iff (!por_n)
    !rst_status |-> (!tx_dig_rst && !rx_dig_rst));

  assert_tx_drop_R8: assert property (@(posedge clk) disable iff (!por_n)
    !tx_pll_lock |=> tx_dig_rst);

  assert_legal_state_R1: assert property (@(posedge clk) disable iff (!por_n)
    det_state != 2'd3);
endmodule

bind link_rst_seq link_rst_seq_chk #(.TX_LOCK_CYCLES(TX_LOCK_CYCLES)) u_chk (
  .clk         (clk),
  .por_n       (por_n),
  .tx_pll_lock (tx_pll_lock),
  .rx_pll_lock (rx_pll_lock),
  .serdes_rst  (serdes_rst),
  .tx_dig_rst  (tx_dig_rst),
  .rx_dig_rst  (rx_dig_rst),
  .rst_status  (rst_status),
  .det_state   (det_state),
  .det_hit     (det_hit)
);

// File: tb/link_rst_seq_bench.sv
`timescale 1ns/1ps
module link_rst_seq_bench;
  localparam int TXC = 127;
  localparam int SIG = 20;

  logic       clk = 1'b0;
  logic       por_n;
  logic       tx_pll_lock, rx_pll_lock, phy_status, sig_det;
  logic [2:0] rx_status;
  logic       serdes_rst, tx_dig_rst, rx_dig_rst, rst_status;
  logic [1:0] det_state;

  int checks = 0;
  int fails  = 0;

  always #10 clk = ~clk;

  link_rst_seq #(.CLK_HZ(50_000_000), .SIG_OVERRIDE(SIG), .TX_LOCK_CYCLES(TXC)) u_link_rst_seq (
    .clk(clk), .por_n(por_n), .tx_pll_lock(tx_pll_lock), .rx_pll_lock(rx_pll_lock),
    .phy_status(phy_status), .rx_status(rx_status), .sig_det(sig_det),
    .serdes_rst(serdes_rst), .tx_dig_rst(tx_dig_rst), .rx_dig_rst(rx_dig_rst),
    .rst_status(rst_status), .det_state(det_state)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_reset_vals(input string tag);
    chk({tag, " serdes_rst"}, serdes_rst, 1);
    chk({tag, " tx_dig_rst"}, tx_dig_rst, 1);
    chk({tag, " rx_dig_rst"}, rx_dig_rst, 1);
    chk({tag, " rst_status"}, rst_status, 1);
    chk({tag, " det_state"},  det_state,  0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    por_n = 1'b0; tx_pll_lock = 1'b1; rx_pll_lock = 1'b0;
    phy_status = 1'b0; rx_status = 3'd0; sig_det = 1'b1;
    step(4);
    chk_reset_vals("R1 power-on");

    por_n = 1'b1;
    step(1);
    chk("R2 serdes released on first edge", serdes_rst, 0);
    chk("R2 tx still held on first edge", tx_dig_rst, 1);
    chk("R4 quiet before first enabled edge", det_state, 0);
    step(TXC - 1);
    chk("R3 tx held at edge 127", tx_dig_rst, 1);
    step(1);
    chk("R3 tx released at edge 128", tx_dig_rst, 0);
    chk("R4 quiet while rx lock low", det_state, 0);
    chk("R7 status high while rx held", rst_status, 1);

    rx_pll_lock = 1'b1;
    step(1);
    chk("R4 active one edge after rx lock", det_state, 1);

    // R5: sweep all non-detect codes with a one-cycle pulse
    for (int v = 0; v < 8; v++) begin
      if (v != 3) begin
        rx_status = 3'(v); phy_status = 1'b1;
        step(1);
        phy_status = 1'b0;
        step(4);
        chk($sformatf("R5 code %0d ignored", v), det_state, 1);
      end
    end
    rx_status = 3'd3; phy_status = 1'b0;
    step(5);
    chk("R5 code 3 without pulse ignored", det_state, 1);

    phy_status = 1'b1;
    step(1);
    phy_status = 1'b0;
    step(1);
    chk("R9 detect not yet visible after two edges", det_state, 1);
    step(1);
    chk("R5 polling on third edge after pulse", det_state, 2);
    chk("R6 rx held on polling entry", rx_dig_rst, 1);
    step(SIG - 1);
    chk("R6 rx held one edge before window", rx_dig_rst, 1);
    step(1);
    chk("R6 rx released at window", rx_dig_rst, 0);
    chk("R7 status low when both released", rst_status, 0);

    // R8/R9: signal-detect drop after release
    sig_det = 1'b0;
    step(2);
    chk("R9 sig drop not seen within two edges", rx_dig_rst, 0);
    step(1);
    chk("R8 rx reasserted on sig drop", rx_dig_rst, 1);
    chk("R7 status high after sig drop", rst_status, 1);
    sig_det = 1'b1;
    step(2 + SIG - 1);
    chk("R8 rx held before full new window", rx_dig_rst, 1);
    step(1);
    chk("R8 rx released after full new window", rx_dig_rst, 0);

    // R8: tx lock drop after release
    tx_pll_lock = 1'b0;
    step(1);
    chk("R8 tx reasserted on lock drop", tx_dig_rst, 1);
    chk("R7 status high after lock drop", rst_status, 1);
    tx_pll_lock = 1'b1;
    step(TXC - 1);
    chk("R8 tx held before full new window", tx_dig_rst, 1);
    step(1);
    chk("R8 tx released after full new window", tx_dig_rst, 0);

    // R1: asynchronous reassert, then R8 mid-window drops at several offsets
    #3 por_n = 1'b0;
    #1 chk_reset_vals("R1 async reassert");
    for (int k = 0; k < 4; k++) begin
      automatic int p = (k == 0) ? 2 : (k == 1) ? 40 : (k == 2) ? 100 : 127;
      por_n = 1'b0; tx_pll_lock = 1'b1;
      step(2);
      por_n = 1'b1;
      step(p);
      tx_pll_lock = 1'b0;
      step(1);
      tx_pll_lock = 1'b1;
      step(TXC - 1);
      chk($sformatf("R8 restart offset %0d held", p), tx_dig_rst, 1);
      step(1);
      chk($sformatf("R8 restart offset %0d released", p), tx_dig_rst, 0);
      chk($sformatf("R4 offset %0d active after restart", p), det_state, 1);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule